// File: doc/BRIEF.md
# Ticket Vending Controller

This block is the sequencing core of a ticket dispenser. It takes five single-cycle button pulses, already cleaned of bounce, and walks the customer through three stages: picking a film, picking how many tickets, and feeding in bills. The four direction buttons change meaning from stage to stage. In the first stage they pick a film. In the second they step the ticket count. In the third each one stands for a bill of fixed value. The centre button confirms the first two stages.

All amounts are unsigned counts of cents, so half-dollar prices are exact. The amount due is the sum of the prices of the tickets chosen. Once the money inserted covers the amount due, the controller shows the change and drives a blink flag for a fixed hold time. It then clears itself and waits for the next customer. A display driver reads the registered outputs to show the stage, film, count and amounts.

Top module: `ticket_ctrl`

## Requirements
- R1: After reset the outputs are: stage 0, film 0, quantity 1, paid 0, change 0, blink 0, and total due 900.
- R2: Stage codes are 0 for film select, 1 for quantity, 2 for payment and 3 for change display. A centre pulse moves stage 0 to 1 and stage 1 to 2, seen in the cycle after the pulse. A centre pulse in stage 2 has no effect.
- R3: In stage 0 a direction pulse selects a film: up gives 1, right gives 2, down gives 3 and left gives 4. When several directions arrive together, up wins over right, right over down, and down over left. A centre pulse in the same cycle takes precedence and the direction is dropped.
- R4: In stage 1, up raises the quantity and stops at 9, and down lowers it and stops at 1. Up wins when both arrive together, and left and right are ignored. In stages 2 and 3 the film and the quantity do not change.
- R5: Film prices in cents are 900, 1350, 1800, 1150 and 750 for films 0 to 4. Total due is the sum of one price per ticket, and it follows a change of film or quantity one cycle later.
- R6: In stage 2 a pulse adds a bill to paid: up adds 100, down 500, left 1000 and right 2000. Only one bill counts per cycle, chosen with the priority of R3.
- R7: In the cycle after the bill that brings paid to or above total due, the stage is 3 and change equals paid minus due. Exact payment gives change 0.
- R8: In stage 3 the blink output is 1 for the first CLK_HZ/2 cycles and then toggles every CLK_HZ/2 cycles. Outside stage 3 it is 0.
- R9: Stage 3 lasts exactly CLK_HZ*HOLD_SEC cycles. After that, every output returns to its R1 value.
- R10: Button pulses during stage 3 are ignored. Paid, change, film and quantity stay put, and the hold time does not shorten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_up | input | 1 | Up button pulse |
| btn_down | input | 1 | Down button pulse |
| btn_left | input | 1 | Left button pulse |
| btn_right | input | 1 | Right button pulse |
| btn_enter | input | 1 | Centre (confirm) button pulse |
| stage | output | 2 | Current stage code |
| movie | output | 3 | Selected film index |
| qty | output | QTY_W | Ticket quantity |
| total_due | output | AMT_W | Amount due, cents |
| paid | output | AMT_W | Amount inserted, cents |
| change | output | AMT_W | Change owed, cents |
| blink | output | 1 | Display-on phase of the change blink |

## Verification
A stage register stuck or advanced early shows at once: the buttons then take the wrong role, so quantity moves when a film was meant or paid grows too soon, in the cycle after the pulse. A wrong price sum or bill priority shows in total_due or paid one to two cycles after the press. A miscounted hold or blink timer only shows at the exit or toggle boundary, so the bench walks the whole change window cycle by cycle with a reduced clock rate.

// File: rtl/ticket_pkg.sv
package ticket_pkg;

  typedef enum logic [1:0] {
    ST_MOVIE  = 2'd0,
    ST_QTY    = 2'd1,
    ST_PAY    = 2'd2,
    ST_CHANGE = 2'd3
  } stage_t;

  localparam int MOVIE_W = 3;

  typedef struct packed {
    logic up;
    logic right;
    logic down;
    logic left;
  } dir_t;

  // Per-ticket price in cents for each film slot
  function automatic logic [15:0] movie_price(input logic [MOVIE_W-1:0] idx);
    case (idx)
      3'd1:    movie_price = 16'd1350;
      3'd2:    movie_price = 16'd1800;
      3'd3:    movie_price = 16'd1150;
      3'd4:    movie_price = 16'd750;
      default: movie_price = 16'd900;
    endcase
  endfunction

  // Bill value in cents for a direction pulse, up > right > down > left
  function automatic logic [15:0] bill_value(input dir_t d);
    if (d.up)         bill_value = 16'd100;
    else if (d.right) bill_value = 16'd2000;
    else if (d.down)  bill_value = 16'd500;
    else if (d.left)  bill_value = 16'd1000;
    else              bill_value = 16'd0;
  endfunction

endpackage

// File: rtl/ticket_stage_fsm.sv
module ticket_stage_fsm
  import ticket_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   enter,
  input  logic   pay_done,
  input  logic   timeout,
  output stage_t stage_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_MOVIE;
    end else begin
      case (stage_q)
        ST_MOVIE:  if (enter)    stage_q <= ST_QTY;
        ST_QTY:    if (enter)    stage_q <= ST_PAY;
        ST_PAY:    if (pay_done) stage_q <= ST_CHANGE;
        ST_CHANGE: if (timeout)  stage_q <= ST_MOVIE;
        default:                 stage_q <= ST_MOVIE;
      endcase
    end
  end

endmodule

// File: rtl/ticket_choice.sv
module ticket_choice
  import ticket_pkg::*;
#(
  parameter int MAX_QTY = 9,
  parameter int QTY_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  stage_t             stage,
  input  logic               enter,
  input  dir_t               dir,
  input  logic               timeout,
  output logic [MOVIE_W-1:0] movie_q,
  output logic [QTY_W-1:0]   qty_q
);

  localparam logic [QTY_W-1:0] QTY_TOP = QTY_W'(MAX_QTY);
  localparam logic [QTY_W-1:0] QTY_ONE = QTY_W'(1);

  always_ff @(posedge clk) begin
    if (rst || timeout) begin
      movie_q <= '0;
      qty_q   <= QTY_ONE;
    end else if (!enter) begin
      if (stage == ST_MOVIE) begin
        if (dir.up)         movie_q <= 3'd1;
        else if (dir.right) movie_q <= 3'd2;
        else if (dir.down)  movie_q <= 3'd3;
        else if (dir.left)  movie_q <= 3'd4;
      end else if (stage == ST_QTY) begin
        if (dir.up) begin
          if (qty_q < QTY_TOP) qty_q <= qty_q + QTY_ONE;
        end else if (dir.down) begin
          if (qty_q > QTY_ONE) qty_q <= qty_q - QTY_ONE;
        end
      end
    end
  end

endmodule

// File: rtl/ticket_cash.sv
module ticket_cash
  import ticket_pkg::*;
#(
  parameter int MAX_QTY = 9,
  parameter int QTY_W   = 4,
  parameter int AMT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  stage_t             stage,
  input  dir_t               dir,
  input  logic [MOVIE_W-1:0] movie,
  input  logic [QTY_W-1:0]   qty,
  input  logic               timeout,
  output logic [AMT_W-1:0]   due_q,
  output logic [AMT_W-1:0]   paid_q,
  output logic [AMT_W-1:0]   change_q,
  output logic               pay_done
);

  localparam logic [AMT_W-1:0] DUE_DEFAULT = AMT_W'(movie_price(3'd0));

  logic [AMT_W-1:0] price;
  logic [AMT_W-1:0] due_sum;
  logic [AMT_W-1:0] bill;
  logic [AMT_W-1:0] new_paid;
  logic             bill_hit;
  logic             paying;

  assign price = AMT_W'(movie_price(movie));

  // Sum one price per ticket slot that is in use
  always_comb begin
    due_sum = '0;
    for (int i = 0; i < MAX_QTY; i++) begin
      if (QTY_W'(i) < qty) due_sum = due_sum + price;
    end
  end

  assign bill     = AMT_W'(bill_value(dir));
  assign bill_hit = dir.up | dir.right | dir.down | dir.left;
  assign paying   = (stage == ST_PAY) && bill_hit;
  assign new_paid = paid_q + bill;
  assign pay_done = paying && (new_paid >= due_q);

  always_ff @(posedge clk) begin
    if (rst || timeout) begin
      due_q    <= DUE_DEFAULT;
      paid_q   <= '0;
      change_q <= '0;
    end else begin
      if (stage == ST_MOVIE || stage == ST_QTY) due_q <= due_sum;
      if (paying)   paid_q   <= new_paid;
      if (pay_done) change_q <= new_paid - due_q;
    end
  end

endmodule

// File: rtl/ticket_blink_timer.sv
module ticket_blink_timer #(
  parameter int unsigned HOLD_CYC = 500_000_000,
  parameter int unsigned HALF_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic active,
  output logic blink_q,
  output logic timeout
);

  localparam int CNT_W  = $clog2(HOLD_CYC);
  localparam int HALF_W = $clog2(HALF_CYC);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(HOLD_CYC - 1);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_CYC - 1);

  logic [CNT_W-1:0]  hold_cnt;
  logic [HALF_W-1:0] half_cnt;

  assign timeout = active && (hold_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      half_cnt <= '0;
      blink_q  <= 1'b0;
    end else if (start) begin
      hold_cnt <= '0;
      half_cnt <= '0;
      blink_q  <= 1'b1;
    end else if (active) begin
      if (timeout) begin
        hold_cnt <= '0;
        half_cnt <= '0;
        blink_q  <= 1'b0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
        if (half_cnt == HALF_LAST) begin
          half_cnt <= '0;
          blink_q  <= ~blink_q;
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ticket_ctrl.sv
module ticket_ctrl
  import ticket_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned HOLD_SEC = 5,
  parameter int          MAX_QTY  = 9,
  parameter int          AMT_W    = 16,
  localparam int         QTY_W    = $clog2(MAX_QTY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_up,
  input  logic             btn_down,
  input  logic             btn_left,
  input  logic             btn_right,
  input  logic             btn_enter,
  output logic [1:0]       stage,
  output logic [2:0]       movie,
  output logic [QTY_W-1:0] qty,
  output logic [AMT_W-1:0] total_due,
  output logic [AMT_W-1:0] paid,
  output logic [AMT_W-1:0] change,
  output logic             blink
);

  localparam int unsigned HOLD_CYC = CLK_HZ * HOLD_SEC;
  localparam int unsigned HALF_CYC = CLK_HZ / 2;

  stage_t             stage_q;
  dir_t               dir;
  logic               pay_done;
  logic               timeout;
  logic [MOVIE_W-1:0] movie_q;

  assign dir = '{up: btn_up, right: btn_right, down: btn_down, left: btn_left};

  ticket_stage_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .enter    (btn_enter),
    .pay_done (pay_done),
    .timeout  (timeout),
    .stage_q  (stage_q)
  );

  ticket_choice #(.MAX_QTY(MAX_QTY), .QTY_W(QTY_W)) u_choice (
    .clk     (clk),
    .rst     (rst),
    .stage   (stage_q),
    .enter   (btn_enter),
    .dir     (dir),
    .timeout (timeout),
    .movie_q (movie_q),
    .qty_q   (qty)
  );

  ticket_cash #(.MAX_QTY(MAX_QTY), .QTY_W(QTY_W), .AMT_W(AMT_W)) u_cash (
    .clk      (clk),
    .rst      (rst),
    .stage    (stage_q),
    .dir      (dir),
    .movie    (movie_q),
    .qty      (qty),
    .timeout  (timeout),
    .due_q    (total_due),
    .paid_q   (paid),
    .change_q (change),
    .pay_done (pay_done)
  );

  ticket_blink_timer #(.HOLD_CYC(HOLD_CYC), .HALF_CYC(HALF_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (pay_done),
    .active  (stage_q == ST_CHANGE),
    .blink_q (blink),
    .timeout (timeout)
  );

  assign stage = stage_q;
  assign movie = movie_q;

endmodule

// File: rtl/ticket_ctrl_checks.sv
module ticket_ctrl_checks #(
  parameter int MAX_QTY = 9,
  parameter int QTY_W   = 4,
  parameter int AMT_W   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             btn_enter,
  input logic [1:0]       stage,
  input logic [2:0]       movie,
  input logic [QTY_W-1:0] qty,
  input logic [AMT_W-1:0] total_due,
  input logic [AMT_W-1:0] paid,
  input logic [AMT_W-1:0] change,
  input logic             blink
);

  a_r4_qty_range: assert property (@(posedge clk) disable iff (rst)
    (qty >= QTY_W'(1)) && (qty <= QTY_W'(MAX_QTY)));

  a_r3_movie_range: assert property (@(posedge clk) disable iff (rst)
    movie <= 3'd4);

  a_r2_enter_advances: assert property (@(posedge clk) disable iff (rst)
    (stage == 2'd0 && btn_enter) |=> (stage == 2'd1));

  a_r4_choice_frozen: assert property (@(posedge clk) disable iff (rst)
    (stage == 2'd2) |=> ($stable(movie) && $stable(qty)));

  a_r6_paid_grows: assert property (@(posedge clk) disable iff (rst)
    (stage == 2'd2) |=> (paid >= $past(paid)));

  a_r7_change_match: assert property (@(posedge clk) disable iff (rst)
    (stage == 2'd3) |-> (paid >= total_due && change == paid - total_due));

  a_r8_blink_idle: assert property (@(posedge clk) disable iff (rst)
    (stage != 2'd3) |-> !blink);

  a_r10_change_frozen: assert property (@(posedge clk) disable iff (rst)
    (stage == 2'd3) |=> (stage == 2'd0 || ($stable(paid) && $stable(change))));

  a_r9_exit_clear: assert property (@(posedge clk) disable iff (rst)
    (stage == 2'd3) |=> (stage != 2'd0 ||
      (paid == '0 && change == '0 && movie == 3'd0 && qty == QTY_W'(1))));

endmodule

bind ticket_ctrl ticket_ctrl_checks #(.MAX_QTY(MAX_QTY), .QTY_W(QTY_W), .AMT_W(AMT_W)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .btn_enter (btn_enter),
  .stage     (stage),
  .movie     (movie),
  .qty       (qty),
  .total_due (total_due),
  .paid      (paid),
  .change    (change),
  .blink     (blink)
);

// File: tb/ticket_ctrl_test.sv
module ticket_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int TB_HZ      = 20;
  localparam int HOLD       = TB_HZ * 5;
  localparam int HALF       = TB_HZ / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_up = 1'b0, b_dn = 1'b0, b_lt = 1'b0, b_rt = 1'b0, b_en = 1'b0;
  logic [1:0]  stage;
  logic [2:0]  movie;
  logic [3:0]  qty;
  logic [15:0] total_due, paid, change;
  logic        blink;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ticket_ctrl #(.CLK_HZ(TB_HZ), .HOLD_SEC(5)) uut (
    .clk(clk), .rst(rst),
    .btn_up(b_up), .btn_down(b_dn), .btn_left(b_lt), .btn_right(b_rt), .btn_enter(b_en),
    .stage(stage), .movie(movie), .qty(qty), .total_due(total_due),
    .paid(paid), .change(change), .blink(blink)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One-cycle pulse; returns at the falling edge after the sampling edge
  task automatic press(input bit u, input bit d, input bit l, input bit r, input bit e);
    @(negedge clk);
    b_up = u; b_dn = d; b_lt = l; b_rt = r; b_en = e;
    @(negedge clk);
    b_up = 0; b_dn = 0; b_lt = 0; b_rt = 0; b_en = 0;
  endtask

  task automatic idle_values(input string req);
    chk(req, "stage", stage, 0);
    chk(req, "movie", movie, 0);
    chk(req, "qty", qty, 1);
    chk(req, "paid", paid, 0);
    chk(req, "change", change, 0);
    chk(req, "blink", blink, 0);
    chk(req, "due", total_due, 900);
  endtask

  task automatic t_reset;
    idle_values("R1");
  endtask

  task automatic t_movie;
    press(0, 0, 0, 1, 0); chk("R3", "movie right", movie, 2);
    press(0, 0, 1, 0, 0); chk("R3", "movie left", movie, 4);
    press(1, 1, 0, 0, 0); chk("R3", "movie up beats down", movie, 1);
    @(negedge clk);       chk("R5", "due film 1", total_due, 1350);
    press(0, 1, 0, 0, 1);
    chk("R2", "enter to qty", stage, 1);
    chk("R3", "enter drops direction", movie, 1);
  endtask

  task automatic t_qty;
    press(0, 1, 0, 0, 0); chk("R4", "qty floor", qty, 1);
    for (int i = 0; i < 10; i++) press(1, 0, 0, 0, 0);
    chk("R4", "qty ceiling", qty, 9);
    @(negedge clk); chk("R5", "due 9 tickets", total_due, 12150);
    press(0, 1, 0, 0, 0); chk("R4", "qty down", qty, 8);
    press(1, 1, 0, 0, 0); chk("R4", "up beats down", qty, 9);
    press(0, 1, 0, 0, 0);
    press(0, 0, 1, 1, 0);
    chk("R4", "left/right ignored qty", qty, 8);
    chk("R4", "left/right ignored movie", movie, 1);
    @(negedge clk); chk("R5", "due 8 tickets", total_due, 10800);
    press(0, 0, 0, 0, 1); chk("R2", "enter to pay", stage, 2);
  endtask

  task automatic change_window(input int exp_paid, input int exp_change, input bit poke);
    for (int i = 0; i < HOLD; i++) begin
      chk("R9", "in change stage", stage, 3);
      chk("R8", "blink phase", blink, ((i / HALF) % 2 == 0) ? 1 : 0);
      chk("R10", "paid held", paid, exp_paid);
      chk("R10", "change held", change, exp_change);
      if (poke && i == 30) begin b_up = 1; b_dn = 1; b_lt = 1; b_rt = 1; b_en = 1; end
      if (poke && i == 31) begin b_up = 0; b_dn = 0; b_lt = 0; b_rt = 0; b_en = 0; end
      @(negedge clk);
    end
    idle_values("R9");
  endtask

  task automatic t_pay;
    press(0, 0, 0, 0, 1); chk("R2", "enter ignored in pay", stage, 2);
    chk("R6", "no bill yet", paid, 0);
    press(0, 0, 0, 1, 0); chk("R6", "right 2000", paid, 2000);
    press(0, 0, 1, 0, 0); chk("R6", "left 1000", paid, 3000);
    press(0, 0, 1, 1, 0); chk("R6", "right beats left", paid, 5000);
    press(0, 1, 0, 0, 0); chk("R6", "down 500", paid, 5500);
    press(1, 0, 0, 0, 0); chk("R6", "up 100", paid, 5600);
    press(0, 0, 0, 1, 0);
    press(0, 0, 0, 1, 0);
    press(0, 0, 1, 0, 0);
    chk("R7", "short of due", stage, 2);
    chk("R6", "paid 10600", paid, 10600);
    press(0, 0, 0, 1, 0);
    chk("R7", "covered", stage, 3);
    chk("R7", "change", change, 1800);
    change_window(12600, 1800, 1'b1);
  endtask

  task automatic t_exact;
    press(0, 0, 0, 0, 1);
    press(0, 0, 0, 0, 1);
    chk("R2", "fast to pay", stage, 2);
    chk("R5", "default due", total_due, 900);
    press(0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) press(1, 0, 0, 0, 0);
    chk("R7", "800 not enough", stage, 2);
    press(1, 0, 0, 0, 0);
    chk("R7", "exact payment", stage, 3);
    chk("R7", "zero change", change, 0);
    change_window(900, 0, 1'b0);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_movie;
    t_qty;
    t_pay;
    t_exact;
    finish_up;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up;
  end

endmodule